// File: doc/BRIEF.md
# AC'97 Receive Slot Gate with Codec-Ready Check

This block sits between the receive deserializer of a serial audio port and its receive FIFO. Each received slot arrives as a parallel word with its slot number and a one-cycle strobe. Slot 0 of each frame is the tag slot, and bit 15 of the tag tells whether the codec is ready. Slots 1 to 12 carry 20-bit data. The block reads the ready bit of each tag. It forwards a data slot to the FIFO push port only when two things hold: the tag of the current frame reported the codec ready, and the slot is enabled in a per-slot mask.

When a tag reports the codec not ready, the whole frame is dropped and a sticky not-ready status flag is raised. The flag feeds an interrupt line through an enable bit. Software clears the flag with a one-cycle clear strobe.

The tag check and the flag apply only while the 2-bit protocol selector holds the AC'97 code. In every other protocol setting, masked slots pass straight through and the flag never sets.

Top module: `ac97_rx_slot_gate`

## Requirements
- R1: The gating and the flag depend on the protocol selector. They are in effect only when `proto_cfg` equals 2'b10. For any other value, `nrdy_flag` never sets, and every data slot enabled in the mask is pushed whatever its tag says.
- R2: A strobed slot 0 arriving with `proto_cfg` = 2'b10 and bit 15 of `slot_word` equal to 0 sets `nrdy_flag` on the next clock edge.
- R3: With `proto_cfg` = 2'b10, no data slot is pushed in either of these cases:
  - it follows a tag whose bit 15 was 0, or
  - no tag has been received since reset.
- R4: With `proto_cfg` = 2'b10, after a tag whose bit 15 was 1, each strobed data slot n (1 to 12) is pushed if bit n-1 of `slot_enable` is 1.
  - `fifo_push` pulses one cycle after the strobe, carrying `slot_word` on `fifo_word` and n on `fifo_slot`.
  - Slots whose mask bit is 0 are not pushed.
- R5: `nrdy_irq` is high exactly when `nrdy_flag` is high and `nrdy_irq_en` is 1.
- R6: `nrdy_flag` stays high until a cycle with `nrdy_clear` = 1. It is low from the following edge, unless R7 applies.
- R7: When a set event of R2 and `nrdy_clear` fall in the same cycle, the flag ends up set.
- R8: The ready decision is taken when the tag is received. It governs only the data slots up to the next tag, so consecutive frames are gated independently.
- R9: A slot 0, and a strobed slot numbered 13 to 15, is never pushed. Cycles without a strobe push nothing.
- R10: While `rst_n` is low, `fifo_push`, `nrdy_flag` and `nrdy_irq` are 0. The ready decision resets to "not ready".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proto_cfg | input | 2 | Protocol selector; 2'b10 selects AC'97 gating |
| slot_strobe | input | 1 | One-cycle marker of a received slot |
| slot_index | input | 4 | Slot number within the frame (0 = tag) |
| slot_word | input | 20 | Received slot contents; tag uses bits 15:0 |
| slot_enable | input | 12 | Bit n-1 enables capture of data slot n |
| nrdy_irq_en | input | 1 | Interrupt enable for the not-ready flag |
| nrdy_clear | input | 1 | One-cycle clear of the not-ready flag |
| fifo_push | output | 1 | FIFO write strobe |
| fifo_word | output | 20 | Data written to the FIFO |
| fifo_slot | output | 4 | Slot number of the written data |
| nrdy_flag | output | 1 | Sticky codec-not-ready status |
| nrdy_irq | output | 1 | Not-ready interrupt |

## Verification
A push is due one clock edge after the strobe of its slot, and a flag change is due one edge after the tag or clear that causes it. The interrupt follows the flag and its enable within the same cycle. Inputs are driven shortly after a rising edge and outputs are sampled on the falling edge. At each sample, the flag and interrupt are compared with a cycle model advanced on the rising edge. Each observed push is popped from a queue of expected (slot, word) pairs that the stimulus tasks build from the mask and the tag. The queue must be empty when the run ends, so a missing push is caught as well as an extra or misordered one.

// File: rtl/ac97g_pkg.sv
`timescale 1ns/1ps
package ac97g_pkg;
   localparam logic [1:0] PROTO_AC97     = 2'b10;
   localparam int unsigned DEF_SLOT_W    = 20;
   localparam int unsigned DEF_TAG_W     = 16;
   localparam int unsigned DEF_READY_BIT = 15;
   localparam int unsigned DEF_N_DATA    = 12;
endpackage

// File: rtl/ac97g_tag_decoder.sv
`timescale 1ns/1ps
module ac97g_tag_decoder
   import ac97g_pkg::*;
#(
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       proto_cfg,
   input  logic             slot_strobe,
   input  logic [IDX_W-1:0] slot_index,
   input  logic             tag_ready_bit,
   output logic             gate_en,
   output logic             ready_q,
   output logic             nrdy_evt
);
   logic tag_seen;

   always_comb begin
      tag_seen = slot_strobe && (slot_index == '0);
      gate_en  = (proto_cfg == PROTO_AC97);
      nrdy_evt = tag_seen && gate_en && !tag_ready_bit;
   end

   // Ready decision latched per frame at the tag slot
   always_ff @(posedge clk) begin
      if (!rst_n)
         ready_q <= 1'b0;
      else if (tag_seen)
         ready_q <= tag_ready_bit;
   end

   assert_ready_holds_between_tags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !tag_seen |=> $stable(ready_q));
endmodule

// File: rtl/ac97g_slot_filter.sv
`timescale 1ns/1ps
module ac97g_slot_filter #(
   parameter int unsigned SLOT_W = 20,
   parameter int unsigned N_DATA = 12,
   parameter int unsigned IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate_en,
   input  logic              ready,
   input  logic              slot_strobe,
   input  logic [IDX_W-1:0]  slot_index,
   input  logic [SLOT_W-1:0] slot_word,
   input  logic [N_DATA-1:0] slot_enable,
   output logic              fifo_push,
   output logic [SLOT_W-1:0] fifo_word,
   output logic [IDX_W-1:0]  fifo_slot
);
   logic [N_DATA-1:0] hit;
   logic              accept;

   // One comparator per data slot; slot 0 and out-of-range numbers never hit
   for (genvar g = 0; g < N_DATA; g++) begin : g_slot_hit
      always_comb hit[g] = slot_strobe && slot_enable[g] &&
                           (slot_index == IDX_W'(g + 1));
   end

   always_comb accept = (|hit) && (!gate_en || ready);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fifo_push <= 1'b0;
         fifo_word <= '0;
         fifo_slot <= '0;
      end else begin
         fifo_push <= accept;
         if (accept) begin
            fifo_word <= slot_word;
            fifo_slot <= slot_index;
         end
      end
   end

   assert_single_slot_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
   assert_push_slot_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |-> (fifo_slot != '0) && (int'(fifo_slot) <= int'(N_DATA)));
endmodule

// File: rtl/ac97g_status_flag.sv
`timescale 1ns/1ps
module ac97g_status_flag #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clear,
   input  logic irq_en,
   output logic flag_q,
   output logic irq
);
   // Set has priority over a simultaneous clear
   always_ff @(posedge clk) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (set_evt)
         flag_q <= 1'b1;
      else if (clear)
         flag_q <= 1'b0;
   end

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= flag_q && irq_en;
      end
   end else begin : g_irq_comb
      always_comb irq = flag_q && irq_en;
      assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> flag_q);
   end

   assert_flag_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> flag_q);
   assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q && !clear |=> flag_q);
   assert_flag_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clear && !set_evt |=> !flag_q);
endmodule

// File: rtl/ac97_rx_slot_gate.sv
`timescale 1ns/1ps
module ac97_rx_slot_gate
   import ac97g_pkg::*;
#(
   parameter int unsigned SLOT_W    = DEF_SLOT_W,
   parameter int unsigned TAG_W     = DEF_TAG_W,
   parameter int unsigned READY_BIT = DEF_READY_BIT,
   parameter int unsigned N_DATA    = DEF_N_DATA,
   parameter int unsigned IDX_W     = $clog2(N_DATA + 1),
   parameter bit          IRQ_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        proto_cfg,
   input  logic              slot_strobe,
   input  logic [IDX_W-1:0]  slot_index,
   input  logic [SLOT_W-1:0] slot_word,
   input  logic [N_DATA-1:0] slot_enable,
   input  logic              nrdy_irq_en,
   input  logic              nrdy_clear,
   output logic              fifo_push,
   output logic [SLOT_W-1:0] fifo_word,
   output logic [IDX_W-1:0]  fifo_slot,
   output logic              nrdy_flag,
   output logic              nrdy_irq
);
   localparam int unsigned MIN_IDX_W = $clog2(N_DATA + 1);

   if (TAG_W > SLOT_W)         begin : g_chk_tag   $error("tag wider than slot"); end
   if (READY_BIT >= TAG_W)     begin : g_chk_rdy   $error("ready bit outside tag"); end
   if (IDX_W < MIN_IDX_W)      begin : g_chk_idx   $error("slot index too narrow"); end
   if (N_DATA < 1)             begin : g_chk_nd    $error("no data slots"); end

   logic gate_en;
   logic ready_q;
   logic nrdy_evt;

   ac97g_tag_decoder #(.IDX_W(IDX_W)) u_tag (
      .clk           (clk),
      .rst_n         (rst_n),
      .proto_cfg     (proto_cfg),
      .slot_strobe   (slot_strobe),
      .slot_index    (slot_index),
      .tag_ready_bit (slot_word[READY_BIT]),
      .gate_en       (gate_en),
      .ready_q       (ready_q),
      .nrdy_evt      (nrdy_evt)
   );

   ac97g_slot_filter #(.SLOT_W(SLOT_W), .N_DATA(N_DATA), .IDX_W(IDX_W)) u_filter (
      .clk         (clk),
      .rst_n       (rst_n),
      .gate_en     (gate_en),
      .ready       (ready_q),
      .slot_strobe (slot_strobe),
      .slot_index  (slot_index),
      .slot_word   (slot_word),
      .slot_enable (slot_enable),
      .fifo_push   (fifo_push),
      .fifo_word   (fifo_word),
      .fifo_slot   (fifo_slot)
   );

   ac97g_status_flag #(.IRQ_REG(IRQ_REG)) u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (nrdy_evt),
      .clear   (nrdy_clear),
      .irq_en  (nrdy_irq_en),
      .flag_q  (nrdy_flag),
      .irq     (nrdy_irq)
   );

   assert_gated_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push && $past(gate_en) |-> $past(ready_q));
   assert_no_flag_outside_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nrdy_flag) |-> $past(gate_en));
endmodule

// File: tb/tb_ac97_rx_slot_gate.sv
`timescale 1ns/1ps
module tb_ac97_rx_slot_gate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  proto_cfg = 2'b10;
   logic        slot_strobe = 1'b0;
   logic [3:0]  slot_index = '0;
   logic [19:0] slot_word = '0;
   logic [11:0] slot_enable = '0;
   logic        nrdy_irq_en = 1'b0;
   logic        nrdy_clear = 1'b0;
   logic        fifo_push;
   logic [19:0] fifo_word;
   logic [3:0]  fifo_slot;
   logic        nrdy_flag;
   logic        nrdy_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   string cur_req = "R10";
   logic [23:0] exp_q[$];
   bit m_flag = 1'b0;

   always #10 clk = ~clk;

   ac97_rx_slot_gate dut (
      .clk(clk), .rst_n(rst_n), .proto_cfg(proto_cfg), .slot_strobe(slot_strobe),
      .slot_index(slot_index), .slot_word(slot_word), .slot_enable(slot_enable),
      .nrdy_irq_en(nrdy_irq_en), .nrdy_clear(nrdy_clear), .fifo_push(fifo_push),
      .fifo_word(fifo_word), .fifo_slot(fifo_slot), .nrdy_flag(nrdy_flag),
      .nrdy_irq(nrdy_irq));

   // Behavioural flag model, advanced on the rising edge
   always @(posedge clk) begin
      if (!rst_n) m_flag <= 1'b0;
      else if (slot_strobe && slot_index == 4'd0 && proto_cfg == 2'b10 && !slot_word[15])
         m_flag <= 1'b1;
      else if (nrdy_clear) m_flag <= 1'b0;
   end

   // Compare on every falling edge
   always @(negedge clk) begin
      if (!rst_n) begin
         checks++;
         if (fifo_push || nrdy_flag || nrdy_irq) begin
            fails++;
            $display("FAIL R10: reset outputs push=%b flag=%b irq=%b expected 0 0 0",
                     fifo_push, nrdy_flag, nrdy_irq);
         end
      end else begin
         checks++;
         if (nrdy_flag !== m_flag) begin
            fails++;
            $display("FAIL %s: nrdy_flag=%b expected %b", cur_req, nrdy_flag, m_flag);
         end
         checks++;
         if (nrdy_irq !== (m_flag && nrdy_irq_en)) begin
            fails++;
            $display("FAIL R5: nrdy_irq=%b expected %b", nrdy_irq, m_flag && nrdy_irq_en);
         end
         if (fifo_push) begin
            checks++;
            if (exp_q.size() == 0) begin
               fails++;
               $display("FAIL %s: push slot=%0d word=%h expected no push",
                        cur_req, fifo_slot, fifo_word);
            end else begin
               logic [23:0] e;
               e = exp_q.pop_front();
               if ({fifo_slot, fifo_word} !== e) begin
                  fails++;
                  $display("FAIL %s: push slot=%0d word=%h expected slot=%0d word=%h",
                           cur_req, fifo_slot, fifo_word, e[23:20], e[19:0]);
               end
            end
         end
      end
   end

   task automatic put(input logic v, input logic [3:0] i, input logic [19:0] w,
                      input logic clr);
      @(posedge clk);
      #2;
      slot_strobe = v;
      slot_index  = i;
      slot_word   = w;
      nrdy_clear  = clr;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) put(1'b0, 4'd0, 20'h0, 1'b0);
   endtask

   // One frame: tag, data slots 1..12 with a gap, then a stray slot 14
   task automatic frame(input bit rdy, input logic [11:0] mask, input int seed,
                        input bit clr_on_tag);
      bit gated;
      gated = (proto_cfg == 2'b10);
      slot_enable = mask;
      put(1'b1, 4'd0, {4'h0, rdy, 15'(seed * 37)}, clr_on_tag);
      for (int n = 1; n <= 12; n++) begin
         logic [19:0] w;
         w = 20'(seed * 4099 + n * 257);
         put(1'b1, 4'(n), w, 1'b0);
         if ((!gated || rdy) && mask[n-1]) exp_q.push_back({4'(n), w});
         if (n == 6) put(1'b0, 4'(7), 20'hABCDE, 1'b0);
      end
      put(1'b1, 4'd14, 20'h5A5A5, 1'b0);
      idle(2);
   endtask

   task automatic queue_empty(input string req);
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL %s: %0d pushes missing, expected 0", req, exp_q.size());
         exp_q.delete();
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      idle(1);
      // R3: data slots before any tag are not pushed
      cur_req = "R3";
      slot_enable = 12'hFFF;
      for (int n = 1; n <= 4; n++) put(1'b1, 4'(n), 20'(n), 1'b0);
      idle(2);
      queue_empty("R3");
      // R4: ready frame, all slots enabled
      cur_req = "R4";
      frame(1'b1, 12'hFFF, 1, 1'b0);
      queue_empty("R4");
      // R2, R3: not-ready frame drops data and sets flag; R5 irq enable
      cur_req = "R2";
      frame(1'b0, 12'hFFF, 2, 1'b0);
      queue_empty("R3");
      nrdy_irq_en = 1'b1;
      idle(2);
      // R6: flag sticky across a ready frame with sparse mask (R8 per frame)
      cur_req = "R6";
      frame(1'b1, 12'h0A5, 3, 1'b0);
      queue_empty("R8");
      put(1'b0, 4'd0, 20'h0, 1'b1);
      idle(2);
      // R8: ready then not-ready frame, decisions independent
      cur_req = "R8";
      frame(1'b1, 12'h801, 4, 1'b0);
      frame(1'b0, 12'h801, 5, 1'b0);
      queue_empty("R8");
      put(1'b0, 4'd0, 20'h0, 1'b1);
      idle(1);
      // R7: clear coincides with a not-ready tag
      cur_req = "R7";
      frame(1'b0, 12'h3C3, 6, 1'b1);
      idle(1);
      put(1'b0, 4'd0, 20'h0, 1'b1);
      idle(1);
      // R1: other protocol, not-ready tag neither sets flag nor blocks data
      cur_req = "R1";
      proto_cfg = 2'b00;
      frame(1'b0, 12'h5F0, 7, 1'b0);
      proto_cfg = 2'b01;
      frame(1'b0, 12'h00F, 8, 1'b0);
      queue_empty("R1");
      // R9: masked-off frame and stray numbers push nothing
      cur_req = "R9";
      proto_cfg = 2'b10;
      frame(1'b1, 12'h000, 9, 1'b0);
      for (int n = 13; n <= 15; n++) put(1'b1, 4'(n), 20'hFFFFF, 1'b0);
      put(1'b1, 4'd0, 20'h08000, 1'b0);
      idle(3);
      queue_empty("R9");
      nrdy_irq_en = 1'b0;
      idle(2);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule